// File: doc/BRIEF.md
# Descriptor Slot Scanner with Skip Map

This block picks, one at a time, which of the transfer descriptor slots of a single transfer class the transaction engine should execute next. Each scheduling period opens with a tick. From then on the scanner walks upward from slot 0. At each step it offers the engine the lowest slot that is eligible and not yet passed. A slot is eligible when its valid bit is set and its skip bit is clear. The engine accepts the offer with a grant and later reports completion. The scanner then clears that slot's valid bit, raises a done event carrying the slot index, and resumes the walk just above that slot.

Software controls the walk through a small register port that holds two values. The skip map removes individual slots from the walk but leaves their descriptors and valid bits untouched, so a slot can be put back later without being rewritten. The last-slot value bounds how far a pass goes. The valid vector is loaded as a whole from descriptor memory. Its current value is presented on an output, so the state a completion clears can be observed.

Top module: `dss_top`

## Requirements
- R1: After reset, `req` and `done` are low, every bit of `slot_valid` is 0, the skip map is all zeros and the last-slot value is NUM_SLOTS-1.
- R2: A pass starts only when `sched_tick` is high while the scanner is idle. Without a tick, no request is raised even when eligible slots exist. A tick that arrives during a pass is ignored.
- R3: A slot i is eligible when `slot_valid[i]` is 1 and skip-map bit i is 0. The slot offered on `req_slot` is the lowest eligible index that is at or above the scan position and not above the last-slot value.
- R4: Once `req` rises, it stays high with `req_slot` unchanged until a cycle in which `gnt` is high. After that cycle `req` is low.
- R5: A completion (`cmpl` high while a granted slot runs, with `cmpl_slot` equal to that slot) clears that slot's valid bit. The clear is visible on `slot_valid` in the next cycle, and `done` pulses for one cycle with `done_slot` equal to the slot. A completion with any other index, or one that arrives while no slot is running, changes nothing.
- R6: After a completion the walk resumes at the next higher index. A pass ends when the completed slot equals the last-slot value or NUM_SLOTS-1, or when no eligible slot remains in the window. After that, no request is raised until the next tick.
- R7: A write to the skip map applies to every slot examined after the write, including later slots of a pass already in progress. A slot that has already been granted still runs to completion. A skipped slot keeps its valid bit set.
- R8: On the register port, `cfg_addr` 0 writes the skip map, with bit i of `cfg_wdata` controlling slot i. `cfg_addr` 1 writes the last-slot value from the low log2(NUM_SLOTS) bits of `cfg_wdata`.
- R9: `vld_load` replaces the whole valid vector with `vld_vec`. When a load and a completion clear hit the same slot in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sched_tick | input | 1 | Start of a scheduling period |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 skip map, 1 last slot |
| cfg_wdata | input | DATA_W | Register write data |
| vld_load | input | 1 | Load the valid vector |
| vld_vec | input | NUM_SLOTS | Valid bits read from descriptor memory |
| slot_valid | output | NUM_SLOTS | Current valid vector |
| req | output | 1 | Slot offered to the transaction engine |
| req_slot | output | IDX_W | Index of the offered slot |
| gnt | input | 1 | Engine accepts the offered slot |
| cmpl | input | 1 | Engine reports completion |
| cmpl_slot | input | IDX_W | Index of the completed slot |
| done | output | 1 | One-cycle completion event |
| done_slot | output | IDX_W | Index of the slot that completed |

## Verification
The walk order is tested with four patterns. A sparse valid vector with nothing skipped shows plain ascending order and ties it to the top index. A vector with skipped slots separates eligibility from validity, and a later un-skip shows that the skipped slots kept their valid bits. A lowered last-slot value shows that a pass ends early while slots above the bound stay pending. A skip-map write made after a grant shows the difference between slots already granted and slots still ahead. Stalled grants, stray completions with a wrong index, ticks during a pass and an idle period without a tick each check that the handshake and the pass boundaries hold.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_REQ  = 2'd2,
    ST_RUN  = 2'd3
  } dss_state_e;

  localparam logic CFG_SEL_SKIP = 1'b0;
  localparam logic CFG_SEL_LAST = 1'b1;
endpackage

// File: rtl/dss_cfg.sv
module dss_cfg #(
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic                 addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [NUM_SLOTS-1:0] skip_map,
  output logic [IDX_W-1:0]     last_slot
);
  import dss_pkg::*;

  logic [NUM_SLOTS-1:0] skip_d;
  logic [IDX_W-1:0]     last_d;
  logic                 skip_en;
  logic                 last_en;

  always_comb begin
    skip_en = we && (addr == CFG_SEL_SKIP);
    last_en = we && (addr == CFG_SEL_LAST);
    skip_d  = wdata[NUM_SLOTS-1:0];
    last_d  = wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_map <= '0;
    end else if (skip_en) begin
      skip_map <= skip_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_slot <= IDX_W'(NUM_SLOTS - 1);
    end else if (last_en) begin
      last_slot <= last_d;
    end
  end

  // R8: a write updates exactly the selected register
  a_r8_skip_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == CFG_SEL_SKIP) |=> skip_map == $past(wdata[NUM_SLOTS-1:0]));
  a_r8_last_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == CFG_SEL_SKIP) |=> $stable(last_slot));
endmodule

// File: rtl/dss_valid.sv
module dss_valid #(
  parameter int NUM_SLOTS = 32,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic [NUM_SLOTS-1:0] load_vec,
  input  logic                 clr_en,
  input  logic [IDX_W-1:0]     clr_idx,
  output logic [NUM_SLOTS-1:0] valid_q
);
  logic [NUM_SLOTS-1:0] valid_d;
  logic [NUM_SLOTS-1:0] clr_mask;
  logic                 upd_en;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_clr
    assign clr_mask[i] = clr_en && (clr_idx == IDX_W'(i));
  end

  always_comb begin
    upd_en  = load_en || clr_en;
    valid_d = (load_en ? load_vec : valid_q) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (upd_en) begin
      valid_q <= valid_d;
    end
  end

  // R9: a clear always wins over a load on the same slot
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !valid_q[$past(clr_idx)]);
endmodule

// File: rtl/dss_pick.sv
module dss_pick #(
  parameter int NUM_SLOTS = 32,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] valid,
  input  logic [NUM_SLOTS-1:0] skip,
  input  logic [IDX_W-1:0]     pos,
  input  logic [IDX_W-1:0]     last,
  output logic                 found,
  output logic [IDX_W-1:0]     idx
);
  logic [NUM_SLOTS-1:0] elig;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_elig
    assign elig[i] = valid[i] && !skip[i] &&
                     (IDX_W'(i) >= pos) && (IDX_W'(i) <= last);
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/dss_top.sv
module dss_top #(
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sched_tick,
  input  logic                 cfg_we,
  input  logic                 cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  input  logic                 vld_load,
  input  logic [NUM_SLOTS-1:0] vld_vec,
  output logic [NUM_SLOTS-1:0] slot_valid,
  output logic                 req,
  output logic [IDX_W-1:0]     req_slot,
  input  logic                 gnt,
  input  logic                 cmpl,
  input  logic [IDX_W-1:0]     cmpl_slot,
  output logic                 done,
  output logic [IDX_W-1:0]     done_slot
);
  import dss_pkg::*;

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_SLOTS - 1);

  dss_state_e           state_q, state_d;
  logic [IDX_W-1:0]     pos_q, pos_d;
  logic [IDX_W-1:0]     cur_q, cur_d;
  logic                 done_d;
  logic [IDX_W-1:0]     done_slot_d;
  logic [NUM_SLOTS-1:0] skip_map;
  logic [IDX_W-1:0]     last_slot;
  logic                 pick_found;
  logic [IDX_W-1:0]     pick_idx;
  logic                 cmpl_ok;
  logic                 pass_end;
  logic                 done_en;

  dss_cfg #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .skip_map  (skip_map),
    .last_slot (last_slot)
  );

  dss_valid #(.NUM_SLOTS(NUM_SLOTS)) u_valid (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (vld_load),
    .load_vec (vld_vec),
    .clr_en   (cmpl_ok),
    .clr_idx  (cur_q),
    .valid_q  (slot_valid)
  );

  dss_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .valid (slot_valid),
    .skip  (skip_map),
    .pos   (pos_q),
    .last  (last_slot),
    .found (pick_found),
    .idx   (pick_idx)
  );

  always_comb begin
    cmpl_ok  = (state_q == ST_RUN) && cmpl && (cmpl_slot == cur_q);
    pass_end = (cur_q == last_slot) || (cur_q == TOP_IDX);
  end

  always_comb begin
    state_d     = state_q;
    pos_d       = pos_q;
    cur_d       = cur_q;
    done_d      = 1'b0;
    done_slot_d = done_slot;
    unique case (state_q)
      ST_IDLE: begin
        if (sched_tick) begin
          state_d = ST_SCAN;
          pos_d   = '0;
        end
      end
      ST_SCAN: begin
        if (pick_found) begin
          state_d = ST_REQ;
          cur_d   = pick_idx;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_REQ: begin
        if (gnt) begin
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (cmpl_ok) begin
          done_d      = 1'b1;
          done_slot_d = cur_q;
          pos_d       = cur_q + 1'b1;
          state_d     = pass_end ? ST_IDLE : ST_SCAN;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign done_en = done_d || done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      cur_q   <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      cur_q   <= cur_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      done_slot <= '0;
    end else if (done_en) begin
      done      <= done_d;
      done_slot <= done_slot_d;
    end
  end

  assign req      = (state_q == ST_REQ);
  assign req_slot = cur_q;

  // R4: an offer is held steady until it is granted
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !gnt) |=> (req && $stable(req_slot)));
  a_r4_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (req && gnt) |=> !req);
  // R5: done follows a completion and leaves the slot invalid
  a_r5_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cmpl));
  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !slot_valid[done_slot]);
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5: a stray completion while an offer is pending has no effect
  a_r5_no_done_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !done);
  // R6: nothing is offered while a completion is being reported
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && done));
endmodule

// File: tb/dss_top_test.sv
module dss_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 32;
  localparam int IW = 5;

  logic          clk;
  logic          rst_n;
  logic          sched_tick;
  logic          cfg_we;
  logic          cfg_addr;
  logic [31:0]   cfg_wdata;
  logic          vld_load;
  logic [N-1:0]  vld_vec;
  logic [N-1:0]  slot_valid;
  logic          req;
  logic [IW-1:0] req_slot;
  logic          gnt;
  logic          cmpl;
  logic [IW-1:0] cmpl_slot;
  logic          done;
  logic [IW-1:0] done_slot;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  int cyc = 0;

  dss_top #(.NUM_SLOTS(N), .DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .sched_tick(sched_tick),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .vld_load(vld_load), .vld_vec(vld_vec), .slot_valid(slot_valid),
    .req(req), .req_slot(req_slot), .gnt(gnt),
    .cmpl(cmpl), .cmpl_slot(cmpl_slot), .done(done), .done_slot(done_slot)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 100000", cyc);
      summary();
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each done event
  always @(negedge clk) begin
    if (rst_n && done) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R3/R5 order: actual done slot %0d expected none", done_slot);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(done_slot) != e) begin
          fails++;
          $display("FAIL R3/R5 order: actual done slot %0d expected %0d", done_slot, e);
        end
      end
    end
  end

  task automatic push_exp(input int s);
    exp_q.push_back(s);
  endtask

  task automatic cfg_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_valid(input logic [N-1:0] v);
    @(negedge clk);
    vld_load = 1'b1; vld_vec = v;
    @(negedge clk);
    vld_load = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    sched_tick = 1'b1;
    @(negedge clk);
    sched_tick = 1'b0;
  endtask

  // Engine model: wait for an offer, hold off the grant, then complete it
  task automatic serve(input int gnt_delay, output int slot);
    int k;
    slot = -1;
    k = 0;
    while (!req && k < 200) begin
      @(negedge clk);
      k++;
    end
    if (!req) begin
      check("R3 request expected", 0, 1);
      return;
    end
    slot = int'(req_slot);
    for (int d = 0; d < gnt_delay; d++) begin
      @(negedge clk);
      check("R4 held offer", {req, req_slot}, {1'b1, IW'(slot)});
    end
    gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0;
    check("R4 offer drops after grant", req, 0);
  endtask

  task automatic finish_slot(input int slot);
    @(negedge clk);
    cmpl = 1'b1; cmpl_slot = IW'(slot);
    @(negedge clk);
    cmpl = 1'b0;
    check("R5 valid bit cleared", slot_valid[slot], 0);
  endtask

  task automatic run_pass(input int count);
    int s;
    for (int i = 0; i < count; i++) begin
      serve(0, s);
      if (s >= 0) finish_slot(s);
    end
    repeat (3) @(negedge clk);
    check("R3 scoreboard drained", exp_q.size(), 0);
  endtask

  task automatic expect_quiet(input string tag, input int n);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (req) seen = 1;
    end
    check(tag, seen, 0);
  endtask

  initial begin
    int s;
    rst_n = 1'b0; sched_tick = 1'b0; cfg_we = 1'b0; cfg_addr = 1'b0;
    cfg_wdata = '0; vld_load = 1'b0; vld_vec = '0; gnt = 1'b0;
    cmpl = 1'b0; cmpl_slot = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 req at reset", req, 0);
    check("R1 done at reset", done, 0);
    check("R1 valid at reset", slot_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: default last slot 31 and empty skip map -> slot 31 served
    load_valid(32'h8000_0000);
    // R2: no tick, no request
    expect_quiet("R2 no request without tick", 10);
    push_exp(31);
    tick();
    run_pass(1);

    // R3 plain ascending order, sparse pattern; R9 whole-vector load
    load_valid(32'h4000_0212);
    check("R9 load visible", slot_valid, 32'h4000_0212);
    push_exp(1); push_exp(4); push_exp(9); push_exp(30);
    tick();
    run_pass(4);
    check("R3 all served", slot_valid, 0);

    // R6 empty pass stays idle
    tick();
    expect_quiet("R6 no eligible slot", 10);

    // R7/R8 skip map: valid {2,3,5,7}, skip {3,7}
    load_valid(32'h0000_00AC);
    cfg_write(1'b0, 32'h0000_0088);
    push_exp(2); push_exp(5);
    tick();
    run_pass(2);
    check("R7 skipped slots keep valid", slot_valid, 32'h0000_0088);
    expect_quiet("R6 pass ended", 5);
    cfg_write(1'b0, 32'h0);
    push_exp(3); push_exp(7);
    tick();
    run_pass(2);

    // R6/R8 last-slot bound: valid {0,10,20}, last = 10
    load_valid(32'h0010_0401);
    cfg_write(1'b1, 32'h0000_000A);
    push_exp(0); push_exp(10);
    tick();
    run_pass(2);
    expect_quiet("R6 stop at last slot", 10);
    check("R6 slot above last pending", slot_valid, 32'h0010_0000);
    cfg_write(1'b1, 32'h0000_001F);
    push_exp(20);
    tick();
    run_pass(1);

    // R7 mid-pass skip: valid {1,6,12}; after grant of 1, skip 1 and 6
    load_valid(32'h0000_1042);
    push_exp(1); push_exp(12);
    tick();
    serve(0, s);
    check("R3 first offer", s, 1);
    cfg_write(1'b0, 32'h0000_0042);
    // R5 stray completion with wrong index is ignored
    @(negedge clk);
    cmpl = 1'b1; cmpl_slot = 5'd6;
    @(negedge clk);
    cmpl = 1'b0;
    check("R5 wrong index no done", done, 0);
    check("R5 wrong index no clear", slot_valid, 32'h0000_1042);
    // R2 tick during pass is ignored
    tick();
    finish_slot(1);
    // R4 stalled grant on slot 12
    serve(4, s);
    check("R7 skipped slot passed over", s, 12);
    finish_slot(s);
    repeat (3) @(negedge clk);
    check("R7 scoreboard drained", exp_q.size(), 0);
    check("R7 skipped slot still valid", slot_valid, 32'h0000_0040);
    expect_quiet("R2 pass not restarted", 10);

    // R9 load and clear on same slot in one cycle: clear wins
    cfg_write(1'b0, 32'h0);
    load_valid(32'h0000_0008);
    push_exp(3);
    tick();
    serve(0, s);
    @(negedge clk);
    cmpl = 1'b1; cmpl_slot = IW'(s); vld_load = 1'b1; vld_vec = 32'h0000_0048;
    @(negedge clk);
    cmpl = 1'b0; vld_load = 1'b0;
    check("R9 clear wins over load", slot_valid, 32'h0000_0040);
    repeat (3) @(negedge clk);
    check("R9 scoreboard drained", exp_q.size(), 0);

    summary();
  end
endmodule